// File: doc/BRIEF.md
# Clock-Loss Trigger Capture Unit

This block is a compact trace engine driven by a fast sample clock. It samples a monitored clock line and a bus of data channels. Whenever the channel bus changes, it stores the new value together with a wide timestamp in a circular buffer. When the monitored clock produces no rising edge for longer than a programmable number of sample cycles, the block fires a trigger. Capture then freezes at once. The buffer therefore holds only the activity that led up to the clock loss.

A second mode suppresses every trigger condition, and capture then runs until an external stop pulse arrives. The timestamp has a default width of 50 bits. At a 200 MHz sample clock it can count for more than a month without wrapping, so the order of events is preserved across a long wait before the stop.

A host reads entries through a registered index port. After the buffer has wrapped, the oldest entry sits at the frozen write pointer. The block also raises a sticky flag when monitored rising edges arrive closer together than the sample clock can resolve. In that case the gap limit, or the monitored clock itself, is suspect.

Top module: `clkloss_capture`

## Requirements
- R1: During and after reset the block is not armed, not triggered and not stopped, with write pointer 0 and the edge error flag low.
- R2: A one-cycle arm pulse enters capture from any state. It clears the write pointer, the timestamp, the gap counter, the trigger and stop flags, and the edge error flag. While capturing, exactly one of armed, triggered and stopped is high; before the first arm none is.
- R3: While armed, an entry is written only in a cycle where the sampled channel bus differs from its value one sample earlier. The write pointer advances by exactly one per write and wraps from DEPTH-1 to 0. Idle periods write nothing.
- R4: Each entry holds the channel value (read on rd_chan_o) and the timestamp (read on rd_ts_o). The timestamp counts sample cycles since arm, so the difference between two entries equals their spacing in sample cycles.
- R5: In normal mode, after the first rising edge of the monitored clock, a trigger fires once the number of sample cycles since the last rising edge reaches gap_lim_i. A clock whose rising-edge spacing P is greater than gap_lim_i triggers. One with P no greater than gap_lim_i never does.
- R6: No gap trigger fires before the first monitored rising edge after arm.
- R7: Once triggered or stopped, channel changes are ignored. The write pointer, the buffer and the timestamp stay frozen until the next arm.
- R8: With free_run_i high the gap trigger is disabled, and capture continues while the monitored clock is dead.
- R9: A stop_i pulse while armed ends capture and sets stopped_o, in either mode.
- R10: A rising edge that comes fewer than MIN_SEP sample cycles after the previous one sets edge_err_o. The flag stays high until the next arm and does not stop capture.
- R11: rd_chan_o and rd_ts_o show the entry at rd_idx_i one cycle after the index is applied. After a wrap, the entry at the frozen pointer is the oldest one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tgt_clk_i | input | 1 | Monitored clock line, sampled as data |
| chan_i | input | CH_W | Monitored data channels |
| arm_i | input | 1 | One-cycle pulse that starts a fresh capture |
| free_run_i | input | 1 | High: ignore the gap trigger and run until stop |
| stop_i | input | 1 | Pulse that ends capture |
| gap_lim_i | input | GAP_W | Gap limit in sample cycles |
| rd_idx_i | input | log2(DEPTH) | Buffer read index |
| rd_chan_o | output | CH_W | Channel value of the entry read |
| rd_ts_o | output | TS_W | Timestamp of the entry read |
| armed_o | output | 1 | Capture in progress |
| trig_o | output | 1 | Capture ended by a clock-loss trigger |
| stopped_o | output | 1 | Capture ended by stop_i |
| edge_err_o | output | 1 | Sticky flag for edges too close together |
| wptr_o | output | log2(DEPTH) | Write pointer, frozen after the end of capture |

## Verification
The corner case that matters most is a spacing exactly equal to the gap limit. A comparison off by one would trigger on a healthy clock, or miss a clock that is marginally too slow. The bench therefore runs pairs of clock periods that sit one cycle either side of the limit. It also holds the monitored line low after arm, to catch a design that fires before any edge has been seen. It changes channels after a trigger and after a stop, which exposes a write pointer or timestamp that keeps moving. Finally, it overruns the buffer and reads back at the frozen pointer. A design that lost the wrap, or placed the oldest entry anywhere else, returns the wrong channel value.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TRIG = 2'd2,
    ST_STOP = 2'd3
  } cap_state_e;
endpackage

// File: rtl/clk_edge_mon.sv
module clk_edge_mon #(
  parameter int GAP_W   = 16,
  parameter int MIN_SEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgt_clk_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [GAP_W-1:0] gap_lim_i,
  output logic             fire_o,
  output logic             edge_err_o
);
  localparam logic [GAP_W-1:0] SEP_M1  = GAP_W'(MIN_SEP - 1);
  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

  logic [2:0]       sync_q;
  logic             rise;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             err_q, err_d;

  // two synchronizer stages, third stage holds the previous sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b000;
    else         sync_q <= {sync_q[1:0], tgt_clk_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    err_d  = err_q;
    if (clr_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      err_d  = 1'b0;
    end else if (run_i) begin
      if (rise) begin
        cnt_d  = '0;
        seen_d = 1'b1;
        if (seen_q && (cnt_q < SEP_M1)) err_d = 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  assign fire_o     = run_i & ~clr_i & seen_q & (cnt_q >= gap_lim_i);
  assign edge_err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q); // R10
  AST_NO_FIRE_UNSEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !fire_o); // R6
endmodule

// File: rtl/trace_buf.sv
module trace_buf #(
  parameter int CH_W  = 8,
  parameter int DEPTH = 16,
  parameter int TS_W  = 50,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = CH_W + TS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic [AW-1:0]   rd_idx_i,
  output logic [CH_W-1:0] rd_chan_o,
  output logic [TS_W-1:0] rd_ts_o,
  output logic [AW-1:0]   wptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CH_W-1:0] smp_q, prev_q;
  logic [TS_W-1:0] ts_q, ts_d;
  logic [AW-1:0]   wptr_q, wptr_d;
  logic            chg, wr_en;
  logic [EW-1:0]   mem [DEPTH];
  logic [EW-1:0]   rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      smp_q  <= chan_i;
      prev_q <= smp_q;
    end
  end

  assign chg   = smp_q != prev_q;
  assign wr_en = run_i & ~clr_i & chg;

  always_comb begin
    ts_d   = ts_q;
    wptr_d = wptr_q;
    if (clr_i) begin
      ts_d   = '0;
      wptr_d = '0;
    end else if (run_i) begin
      ts_d = ts_q + 1'b1;
      if (wr_en) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= '0;
      wptr_q <= '0;
    end else begin
      ts_q   <= ts_d;
      wptr_q <= wptr_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wptr_q] <= {smp_q, ts_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem[rd_idx_i];
  end

  assign rd_chan_o = rd_q[EW-1:TS_W];
  assign rd_ts_o   = rd_q[TS_W-1:0];
  assign wptr_o    = wptr_q;

  AST_WPTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(wptr_q)); // R7
  AST_TS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(ts_q)); // R7
  AST_WPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && wptr_q != LAST) |=>
      (wptr_q == $past(wptr_q)) || (wptr_q == $past(wptr_q) + 1'b1)); // R3
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_q == prev_q) |=> $stable(wptr_q) || $past(clr_i)); // R3
endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
  import cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic free_run_i,
  input  logic stop_i,
  input  logic fire_i,
  output logic run_o,
  output logic trig_o,
  output logic stopped_o
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (arm_i)                        state_d = ST_RUN;
        else if (fire_i && !free_run_i)   state_d = ST_TRIG;
        else if (stop_i)                  state_d = ST_STOP;
      end
      ST_IDLE, ST_TRIG, ST_STOP: begin
        if (arm_i) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o     = state_q == ST_RUN;
  assign trig_o    = state_q == ST_TRIG;
  assign stopped_o = state_q == ST_STOP;

  AST_TRIG_ONLY_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $past(run_o)); // R5
  AST_STOP_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && stop_i && !arm_i) |=> !run_o); // R9
endmodule

// File: rtl/clkloss_capture.sv
module clkloss_capture #(
  parameter int CH_W    = 8,
  parameter int DEPTH   = 16,
  parameter int TS_W    = 50,
  parameter int GAP_W   = 16,
  parameter int MIN_SEP = 4,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgt_clk_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             arm_i,
  input  logic             free_run_i,
  input  logic             stop_i,
  input  logic [GAP_W-1:0] gap_lim_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [CH_W-1:0]  rd_chan_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic             armed_o,
  output logic             trig_o,
  output logic             stopped_o,
  output logic             edge_err_o,
  output logic [AW-1:0]    wptr_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic       run, fire;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  clk_edge_mon #(.GAP_W(GAP_W), .MIN_SEP(MIN_SEP)) mon_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tgt_clk_i  (tgt_clk_i),
    .clr_i      (arm_i),
    .run_i      (run),
    .gap_lim_i  (gap_lim_i),
    .fire_o     (fire),
    .edge_err_o (edge_err_o)
  );

  trace_buf #(.CH_W(CH_W), .DEPTH(DEPTH), .TS_W(TS_W)) buf_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (arm_i),
    .run_i     (run),
    .chan_i    (chan_i),
    .rd_idx_i  (rd_idx_i),
    .rd_chan_o (rd_chan_o),
    .rd_ts_o   (rd_ts_o),
    .wptr_o    (wptr_o)
  );

  capture_fsm fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .arm_i      (arm_i),
    .free_run_i (free_run_i),
    .stop_i     (stop_i),
    .fire_i     (fire),
    .run_o      (run),
    .trig_o     (trig_o),
    .stopped_o  (stopped_o)
  );

  assign armed_o = run;

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({armed_o, trig_o, stopped_o})); // R2
  AST_NO_TRIG_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(trig_o) |-> !$past(free_run_i)); // R8
  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    arm_i |=> (armed_o && wptr_o == '0 && !edge_err_o)); // R2
endmodule

// File: tb/clkloss_capture_tb_top.sv
module clkloss_capture_tb_top;
  localparam int CH_W = 8, DEPTH = 16, TS_W = 50, GAP_W = 16, AW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tgt = 1'b0;
  logic [CH_W-1:0]  chan = '0;
  logic             arm = 1'b0, free_run = 1'b0, stop = 1'b0;
  logic [GAP_W-1:0] lim = 16'd10;
  logic [AW-1:0]    rd_idx = '0;
  logic [CH_W-1:0]  rd_chan;
  logic [TS_W-1:0]  rd_ts;
  logic             armed, trig, stopped, err;
  logic [AW-1:0]    wptr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  clkloss_capture #(.CH_W(CH_W), .DEPTH(DEPTH), .TS_W(TS_W), .GAP_W(GAP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tgt_clk_i(tgt), .chan_i(chan), .arm_i(arm),
    .free_run_i(free_run), .stop_i(stop), .gap_lim_i(lim), .rd_idx_i(rd_idx),
    .rd_chan_o(rd_chan), .rd_ts_o(rd_ts), .armed_o(armed), .trig_o(trig),
    .stopped_o(stopped), .edge_err_o(err), .wptr_o(wptr)
  );

  // half period, gap limit, expected trigger, expected edge error
  localparam int NV = 6;
  localparam int VH [NV] = '{1, 2, 2, 3, 3, 4};
  localparam int VL [NV] = '{20, 4, 3, 6, 5, 20};
  localparam int VT [NV] = '{0, 0, 1, 0, 1, 0};
  localparam int VE [NV] = '{1, 0, 0, 0, 0, 0};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic toggle(input int h, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % h == 0) tgt = ~tgt;
    end
  endtask

  task automatic rd(input int idx, output longint c, output longint t);
    @(negedge clk) rd_idx = AW'(idx);
    @(negedge clk);
    c = rd_chan;
    t = rd_ts;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint c0, t0, c1, t1;
    idle(3);
    chk("R1 armed in reset", armed, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 armed", armed, 0);
    chk("R1 trig", trig, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 wptr", wptr, 0);
    chk("R1 err", err, 0);

    // R5 / R10: table of clock periods against gap limits
    for (int v = 0; v < NV; v++) begin
      lim = GAP_W'(VL[v]);
      tgt = 1'b0;
      do_arm();
      toggle(VH[v], 64);
      chk("R5 trigger vs spacing", trig, VT[v]);
      chk("R10 edge error", err, VE[v]);
    end

    // R2 re-arm after error row leftovers
    lim = 16'd3;
    tgt = 1'b0;
    do_arm();
    chk("R2 armed", armed, 1);
    chk("R2 trig cleared", trig, 0);
    chk("R2 wptr cleared", wptr, 0);
    chk("R2 err cleared", err, 0);
    // R6: no edge ever seen, tight limit
    idle(40);
    chk("R6 no trigger without edge", trig, 0);
    chk("R6 still armed", armed, 1);

    // R3 / R4: transition-only recording
    @(negedge clk) chan = 8'h11;
    idle(7);
    chan = 8'h22;
    idle(30);
    chk("R3 two writes", wptr, 2);
    rd(0, c0, t0);
    rd(1, c1, t1);
    chk("R4 entry0 chan", c0, 'h11);
    chk("R4 entry1 chan", c1, 'h22);
    chk("R4 ts spacing", t1 - t0, 7);
    idle(20);
    chk("R3 idle no write", wptr, 2);

    // R9 / R7: stop in normal mode, then ignored changes
    do_stop();
    chk("R9 stopped", stopped, 1);
    chk("R9 not armed", armed, 0);
    @(negedge clk) chan = 8'h33;
    idle(10);
    chk("R7 wptr frozen after stop", wptr, 2);

    // R5 / R7: clock loss
    lim = 16'd10;
    tgt = 1'b0;
    do_arm();
    @(negedge clk) chan = 8'h44;
    toggle(2, 40);
    idle(5);
    chk("R5 no early trigger", trig, 0);
    idle(30);
    chk("R5 trigger on loss", trig, 1);
    chk("R5 not armed", armed, 0);
    chk("R7 wptr at trigger", wptr, 1);
    @(negedge clk) chan = 8'h55;
    idle(10);
    chk("R7 wptr frozen after trigger", wptr, 1);
    rd(0, c0, t0);
    chk("R7 entry kept", c0, 'h44);

    // R8: free-run ignores clock loss
    free_run = 1'b1;
    tgt = 1'b0;
    do_arm();
    toggle(2, 20);
    idle(60);
    chk("R8 no trigger in free run", trig, 0);
    chk("R8 still armed", armed, 1);
    do_stop();
    chk("R8 stop ends free run", stopped, 1);
    free_run = 1'b0;

    // R11 / R3: wrap and oldest entry
    do_arm();
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk) chan = CH_W'(k);
      idle(2);
    end
    idle(5);
    do_stop();
    chk("R3 wrapped pointer", wptr, 4);
    rd(4, c0, t0);
    rd(5, c1, t1);
    chk("R11 oldest at pointer", c0, 5);
    chk("R11 next entry", c1, 6);
    chk("R4 ts spacing wrap", t1 - t0, 3);
    rd(3, c0, t0);
    chk("R11 newest entry", c0, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule